// File: doc/BRIEF.md
# Multichannel Bitstream Peak Meter

This block measures the short-term peak level of several parallel one-bit delta-sigma audio streams. Each stream runs at 64 samples per 44.1 kHz output period. Every channel has its own smoothing stage. The stage reads each bit as +1 or -1 and sums the most recent TAPS values over a sliding window. The result is a signed level between -TAPS and +TAPS.

Within each output frame, a per-channel tracker keeps the largest magnitude of that level. At the last sample of the frame, the tracker hands its value to a per-channel output register and starts again from zero. The frame length is FRAME_LEN enabled samples and is counted internally. A sync input can end the running frame early, which realigns the count to an external frame clock. A one-cycle pulse announces each new set of peak words.

The window sum is built in one of two ways, chosen by a parameter. One keeps a running total. The other recounts the whole window every sample. Both give identical results at the ports.

Top module: `bitstream_peak_meter`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after that edge, every field of `peak_out` is 0 and `peak_valid` is 0.
- R2: A data bit of 1 counts as +1 and a bit of 0 counts as -1. A channel's level after an accepted sample is the sum of that sample and the TAPS-1 accepted samples before it. Right after reset, the history is treated as alternating values: the most recent is 0, the one before is 1, and so on.
- R3: At a frame's end, a channel's peak word equals the largest absolute level over all samples accepted in that frame, the final sample included. Channel c occupies `peak_out[c*PEAK_W +: PEAK_W]`, where PEAK_W = clog2(TAPS+1).
- R4: A frame ends on every FRAME_LEN-th accepted sample. The new peak words and a `peak_valid` pulse one cycle wide appear in the cycle right after the edge that accepts that sample. Each frame produces exactly one pulse.
- R5: A frame's peak ignores the levels of earlier frames. Tracking starts again from 0 after every frame end.
- R6: A sample accepted with `sync_in` high ends the frame at that sample, whatever the count. The next accepted sample then starts a new frame of FRAME_LEN samples.
- R7: Edges where `sample_en` is low change nothing. Values on `data_in` and `sync_in` at such edges have no effect on any later peak word or on frame timing.
- R8: Each channel's level and peak depend only on its own data bit.
- R9: A channel that receives TAPS equal bits in a row reports the full-scale peak TAPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Accepts one sample on every channel at this edge |
| data_in | input | NUM_CH | One bitstream bit per channel |
| sync_in | input | 1 | Ends the running frame at the accepted sample |
| peak_out | output | NUM_CH*PEAK_W | Latched peak magnitude per channel |
| peak_valid | output | 1 | One-cycle pulse when new peak words are available |

## Verification
The frame-end handoff and the sample update fall on the same edge. The last sample of a frame has to be compared against the running peak and then moved to the output register, while the working peak clears at that same edge. The bench provokes this with patterns whose largest magnitude arrives on the final sample of a frame, and also with back-to-back sync samples that make one-sample frames. In the second case, clearing and capturing happen at the same edge on consecutive cycles. A scoreboard model judges every case: it counts window bits from scratch and stamps each expected result with the cycle its pulse must appear in.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
   localparam int DEF_NUM_CH    = 8;
   localparam int DEF_TAPS      = 28;
   localparam int DEF_FRAME_LEN = 64;

   // magnitude width able to hold 0..taps
   function automatic int mag_width(input int taps);
      return $clog2(taps + 1);
   endfunction
endpackage

// File: rtl/bsm_frame_timer.sv
module bsm_frame_timer #(
   parameter int FRAME_LEN = bsm_pkg::DEF_FRAME_LEN
) (
   input  logic clk,
   input  logic rst,
   input  logic sample_en,
   input  logic sync_in,
   output logic frame_end
);
   localparam int CNT_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   if (FRAME_LEN < 2) begin : g_bad_len
      $error("FRAME_LEN must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign frame_end = sample_en && (sync_in || cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst)            cnt_q <= '0;
      else if (frame_end) cnt_q <= '0;
      else if (sample_en) cnt_q <= cnt_q + 1'b1;
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);
   // R7
   cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !sample_en |=> $stable(cnt_q));
endmodule

// File: rtl/bsm_boxcar.sv
module bsm_boxcar #(
   parameter int TAPS    = bsm_pkg::DEF_TAPS,
   parameter bit RECOUNT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic sample_en,
   input  logic bit_in,
   output logic [bsm_pkg::mag_width(TAPS)-1:0] mag_next
);
   localparam int MAG_W = bsm_pkg::mag_width(TAPS);
   localparam int SUM_W = MAG_W + 1;

   if (TAPS < 2 || (TAPS % 2) != 0) begin : g_bad_taps
      $error("TAPS must be even and at least 2");
   end

   logic [TAPS-1:0]         dl_q;
   logic [TAPS-1:0]         dl_nx;
   logic signed [SUM_W-1:0] sum_nx;
   logic signed [SUM_W-1:0] sum_neg;

   assign dl_nx = {dl_q[TAPS-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < TAPS; i++) dl_q[i] <= 1'(i % 2);
      end else if (sample_en) begin
         dl_q <= dl_nx;
      end
   end

   if (RECOUNT) begin : g_recount
      logic [MAG_W-1:0] ones;
      logic [SUM_W:0]   twice;
      always_comb begin
         ones = '0;
         for (int i = 0; i < TAPS; i++) ones = ones + MAG_W'(dl_nx[i]);
         twice  = {1'b0, ones, 1'b0} - (SUM_W + 1)'(TAPS);
         sum_nx = twice[SUM_W-1:0];
      end
   end else begin : g_running
      logic signed [SUM_W-1:0] sum_q;
      logic signed [SUM_W-1:0] delta;
      always_comb begin
         case ({bit_in, dl_q[TAPS-1]})
            2'b10:   delta = SUM_W'(2);
            2'b01:   delta = -SUM_W'(2);
            default: delta = '0;
         endcase
         sum_nx = sum_q + delta;
      end
      always_ff @(posedge clk) begin
         if (rst)            sum_q <= '0;
         else if (sample_en) sum_q <= sum_nx;
      end
   end

   assign sum_neg  = -sum_nx;
   assign mag_next = sum_nx[SUM_W-1] ? sum_neg[MAG_W-1:0] : sum_nx[MAG_W-1:0];

   // R2
   sum_range_chk: assert property (@(posedge clk) disable iff (rst)
      (sum_nx <= SUM_W'(TAPS)) && (sum_nx >= -SUM_W'(TAPS)));
   // R2
   sum_even_chk: assert property (@(posedge clk) disable iff (rst) sum_nx[0] == 1'b0);
   // R7
   dl_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !sample_en |=> $stable(dl_q));
endmodule

// File: rtl/bsm_peak_hold.sv
module bsm_peak_hold #(
   parameter int MAG_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_en,
   input  logic             frame_end,
   input  logic [MAG_W-1:0] mag,
   output logic [MAG_W-1:0] peak_q
);
   logic [MAG_W-1:0] work_q;
   logic [MAG_W-1:0] cand;

   assign cand = (mag > work_q) ? mag : work_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         work_q <= '0;
         peak_q <= '0;
      end else if (sample_en) begin
         if (frame_end) begin
            peak_q <= cand;
            work_q <= '0;
         end else begin
            work_q <= cand;
         end
      end
   end

   // R5
   work_clear_chk: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> work_q == '0);
   // R3
   work_mono_chk: assert property (@(posedge clk) disable iff (rst)
      (sample_en && !frame_end) |=> work_q >= $past(work_q));
   // R7
   peak_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !frame_end |=> $stable(peak_q));
endmodule

// File: rtl/bitstream_peak_meter.sv
module bitstream_peak_meter #(
   parameter int NUM_CH    = bsm_pkg::DEF_NUM_CH,
   parameter int TAPS      = bsm_pkg::DEF_TAPS,
   parameter int FRAME_LEN = bsm_pkg::DEF_FRAME_LEN,
   parameter bit RECOUNT   = 1'b0
) (
   input  logic                                           clk,
   input  logic                                           rst,
   input  logic                                           sample_en,
   input  logic [NUM_CH-1:0]                              data_in,
   input  logic                                           sync_in,
   output logic [NUM_CH*bsm_pkg::mag_width(TAPS)-1:0]     peak_out,
   output logic                                           peak_valid
);
   localparam int PEAK_W = bsm_pkg::mag_width(TAPS);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end

   logic frame_end;

   bsm_frame_timer #(.FRAME_LEN(FRAME_LEN)) i_timer (
      .clk       (clk),
      .rst       (rst),
      .sample_en (sample_en),
      .sync_in   (sync_in),
      .frame_end (frame_end)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [PEAK_W-1:0] mag;

      bsm_boxcar #(.TAPS(TAPS), .RECOUNT(RECOUNT)) i_boxcar (
         .clk       (clk),
         .rst       (rst),
         .sample_en (sample_en),
         .bit_in    (data_in[c]),
         .mag_next  (mag)
      );

      bsm_peak_hold #(.MAG_W(PEAK_W)) i_hold (
         .clk       (clk),
         .rst       (rst),
         .sample_en (sample_en),
         .frame_end (frame_end),
         .mag       (mag),
         .peak_q    (peak_out[c*PEAK_W +: PEAK_W])
      );

      // R3
      peak_scale_chk: assert property (@(posedge clk) disable iff (rst)
         peak_out[c*PEAK_W +: PEAK_W] <= PEAK_W'(TAPS));
   end

   always_ff @(posedge clk) begin
      if (rst) peak_valid <= 1'b0;
      else     peak_valid <= frame_end;
   end

   // R4
   valid_src_chk: assert property (@(posedge clk) disable iff (rst)
      peak_valid |-> $past(sample_en));
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (peak_valid == 1'b0) && (peak_out == '0));
endmodule

// File: tb/test_bitstream_peak_meter.sv
module test_bitstream_peak_meter;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 8;
   localparam int TAPS  = 28;
   localparam int FLEN  = 64;
   localparam int PW    = 5;

   typedef struct packed {
      int               cyc;
      logic [NCH*PW-1:0] pk;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sample_en = 1'b0;
   logic [NCH-1:0] data_in = '0;
   logic sync_in = 1'b0;
   logic [NCH*PW-1:0] peak_out;
   logic peak_valid;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   exp_t q[$];

   // model state
   logic [TAPS-1:0] hist [NCH];
   int mpeak [NCH];
   int mcnt;

   bitstream_peak_meter i_bitstream_peak_meter (
      .clk(clk), .rst(rst), .sample_en(sample_en), .data_in(data_in),
      .sync_in(sync_in), .peak_out(peak_out), .peak_valid(peak_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) begin
         hist[c]  = 28'hAAAAAAA;
         mpeak[c] = 0;
      end
      mcnt = 0;
      q.delete();
   endtask

   function automatic logic pat(int c, int idx, int phase);
      case ((c + phase) % 6)
         0: return 1'b1;
         1: return 1'b0;
         2: return 1'(idx % 2);
         3: return 1'($urandom % 2);
         4: return 1'((idx / 16) % 2);
         default: return 1'((idx % 4) != 0);
      endcase
   endfunction

   // driver: one accepted sample, model updated, expected item pushed at frame end
   task automatic send(input logic [NCH-1:0] bits, input logic sync);
      exp_t e;
      @(negedge clk);
      sample_en = 1'b1; data_in = bits; sync_in = sync;
      for (int c = 0; c < NCH; c++) begin
         int lvl;
         hist[c] = {hist[c][TAPS-2:0], bits[c]};
         lvl = 2 * $countones(hist[c]) - TAPS;
         if (lvl < 0) lvl = -lvl;
         if (lvl > mpeak[c]) mpeak[c] = lvl;
      end
      if (sync || mcnt == FLEN - 1) begin
         e.cyc = cyc + 1;
         for (int c = 0; c < NCH; c++) begin
            e.pk[c*PW +: PW] = PW'(mpeak[c]);
            mpeak[c] = 0;
         end
         q.push_back(e);
         mcnt = 0;
      end else begin
         mcnt++;
      end
   endtask

   // R7: idle edges with junk on data and sync
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sample_en = 1'b0;
         data_in = NCH'($urandom);
         sync_in = 1'($urandom % 2);
      end
   endtask

   task automatic run_frame(input int phase, input int len, input logic gaps);
      for (int i = 0; i < len; i++) begin
         logic [NCH-1:0] b;
         for (int c = 0; c < NCH; c++) b[c] = pat(c, i, phase);
         send(b, 1'b0);
         if (gaps && (i % 7 == 3)) idle(2);
      end
   endtask

   task automatic check_reset_state(input string tag);
      checks++;
      if (peak_out !== '0 || peak_valid !== 1'b0) begin
         errors++;
         $display("FAIL %s R1 reset state: peak_out=%h valid=%b expected 0/0",
                  tag, peak_out, peak_valid);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && peak_valid) begin
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4 unexpected peak_valid at cycle %0d: actual 1 expected 0", cyc);
         end else begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.cyc != cyc) begin
               errors++;
               $display("FAIL R4 pulse timing: actual cycle %0d expected %0d", cyc, e.cyc);
            end
            for (int c = 0; c < NCH; c++) begin
               checks++;
               // R3 R5 R8 R9
               if (peak_out[c*PW +: PW] !== e.pk[c*PW +: PW]) begin
                  errors++;
                  $display("FAIL R3 ch%0d peak: actual %0d expected %0d",
                           c, peak_out[c*PW +: PW], e.pk[c*PW +: PW]);
               end
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check_reset_state("R1 initial");
      rst = 1'b0;
      // R2 R3 R4 R8 R9: several pattern mixes, with idle gaps (R7)
      run_frame(0, FLEN, 1'b1);
      run_frame(1, FLEN, 1'b0);
      run_frame(2, FLEN, 1'b1);
      // R5: full scale then quiet alternating on all channels
      for (int i = 0; i < FLEN; i++) send('1, 1'b0);
      for (int i = 0; i < FLEN; i++) send({NCH{1'(i % 2)}}, 1'b0);
      // peak at the very last sample of a frame
      for (int i = 0; i < FLEN - 1; i++) send({NCH{1'(i % 2)}}, 1'b0);
      send('0, 1'b0);
      // R6: early sync mid frame, then back-to-back syncs
      run_frame(3, 20, 1'b0);
      send(8'h5A, 1'b1);
      send(8'hFF, 1'b1);
      send(8'h00, 1'b1);
      run_frame(4, FLEN, 1'b1);
      idle(3);
      run_frame(5, FLEN + 10, 1'b0);
      idle(4);
      // mid-frame reset
      @(negedge clk);
      sample_en = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check_reset_state("R1 mid-run");
      model_reset();
      @(negedge clk);
      check_reset_state("R1 held");
      rst = 1'b0;
      run_frame(0, FLEN, 1'b0);
      run_frame(3, FLEN, 1'b1);
      idle(5);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R4 missing pulses: actual %0d pending expected 0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule